// File: doc/BRIEF.md
# Trigger primitive frame builder

Once per bunch crossing this block turns the hit reports it has collected into one trigger frame. A frame opens with the current 12-bit crossing ID. Up to five 16-bit hit primitives follow it. Front-end boards deliver hits through one shared valid/ready port. A hit names its board, its channel, a two-bit sub-crossing time and the crossing ID at which it was seen. Hits do not need to arrive at a fixed latency.

A hit is stored in a 16-entry pending queue. Its age is the current crossing ID minus the crossing in which it was seen, taken modulo 4096. When the crossing strobe arrives, the block packs the five oldest encodable hits into the frame. Each one carries its age as a negative crossing offset. Hits too old to encode are discarded and counted. Hits that do not fit in the frame stay queued for later crossings.

Top module: `tp_frame_builder`

## Requirements
- R1: After reset the crossing ID is 0. Each cycle with `bx_tick` high produces exactly one frame: `frame_valid` is high in the following cycle only. The frame carries the crossing ID from before the tick. The ID then increments by one and wraps from 4095 to 0.
- R2: A primitive is `{board[15:11], channel[10:6], subtime[5:4], offset[3:0]}`. The offset is the negated age as a 4-bit two's-complement value: age 0 gives 0, and age 15 gives 4'b0001.
- R3: `frame_data[91:80]` holds the crossing ID. Primitive slot k (0 to 4) occupies `frame_data[79-16k -: 16]`.
- R4: When a frame is built, every queued hit whose age exceeds 15 is removed without being sent. This includes a hit stamped with a crossing later than the current one. `drop_count` rises by the number removed.
- R5: A frame carries at most five hits, taken in order of decreasing age. Encodable hits that are not sent stay queued for the following frames.
- R6: A queued hit left behind at age 15 reaches age 16 by the next frame and is dropped there.
- R7: Filled slots start at slot 0 and hold the oldest hit first. Unused slots hold 16'hFFFF.
- R8: The queue holds 16 hits. `hit_ready` is low while it is full, and a hit offered while `hit_ready` is low is not accepted.
- R9: A hit accepted in the same cycle as `bx_tick` is not part of that frame. Its age is taken from the next frame on.
- R10: `drop_count` saturates at 255.
- R11: Out of reset `frame_valid` is low, `hit_ready` is high and `drop_count` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bx_tick | input | 1 | Crossing strobe: build a frame, then advance the crossing ID |
| hit_valid | input | 1 | Hit offered on the hit fields |
| hit_ready | output | 1 | Queue can accept a hit |
| hit_board | input | 5 | Board number of the hit |
| hit_chan | input | 5 | Channel number of the hit |
| hit_subt | input | 2 | Sub-crossing time of the hit |
| hit_bx | input | 12 | Crossing ID in which the hit was seen |
| frame_valid | output | 1 | Frame strobe, one cycle |
| frame_data | output | 92 | Crossing ID followed by five primitive slots |
| drop_count | output | 8 | Saturating count of discarded hits |

## Verification
The bench targets the age boundary at 15 and 16. A design off by one there would either emit a hit that cannot be encoded or drop a legal one. It also covers a hit stamped in the future and the crossing ID wrap from 4095 to 0, where ages taken without modular arithmetic come out huge and the hit is lost. Overflow is covered from two sides. With seven hits the frame must hold the five oldest in order, and a design that sorts wrongly or forgets the leftovers shows wrong offsets or missing hits in the next frame. With a full queue a seventeenth hit must be refused: the drained frames then hold 5, 5, 5 and 1 hits rather than 2 in the last. A hit arriving in the tick cycle, and drop counter saturation after 256 drops, close the set.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  localparam int BOARD_W = 5;
  localparam int CHAN_W  = 5;
  localparam int SUBT_W  = 2;
  localparam int OFF_W   = 4;
  localparam int BX_W    = 12;
  localparam int PRIM_W  = BOARD_W + CHAN_W + SUBT_W + OFF_W;

  typedef struct packed {
    logic [BOARD_W-1:0] board;
    logic [CHAN_W-1:0]  chan;
    logic [SUBT_W-1:0]  subt;
    logic [BX_W-1:0]    bx;
  } hit_t;

  localparam logic [PRIM_W-1:0] EMPTY_PRIM = '1;
endpackage

// File: rtl/tpf_hit_store.sv
module tpf_hit_store
  import tpf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  hit_t                   in_hit,
  input  logic [DEPTH-1:0]       clr,
  output logic [DEPTH-1:0]       vld,
  output hit_t [DEPTH-1:0]       ent,
  output logic                   in_ready
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q, vld_d;
  hit_t [DEPTH-1:0] ent_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;
  logic             accept;

  // lowest free position
  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !free_found) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  assign accept   = in_valid && free_found;
  assign in_ready = free_found;

  always_comb begin
    vld_d = vld_q & ~clr;
    if (accept) vld_d[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= '0;
    else if (accept) ent_q[free_idx] <= in_hit;
  end

  assign vld = vld_q;
  assign ent = ent_q;

  // R8
  insert_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && clr == '0) |=> ($countones(vld_q) == $countones($past(vld_q)) + 1));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && clr == '0) |=> $stable(vld_q));
endmodule

// File: rtl/tpf_rank_select.sv
module tpf_rank_select
  import tpf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int SLOTS   = 5,
  parameter int MAX_AGE = 15,
  localparam int RANK_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [BX_W-1:0]               cur_bx,
  input  logic [DEPTH-1:0]              vld,
  input  hit_t [DEPTH-1:0]              ent,
  output logic [SLOTS-1:0][PRIM_W-1:0]  prims,
  output logic [DEPTH-1:0]              clr,
  output logic [RANK_W-1:0]             n_expired
);
  logic [DEPTH-1:0][BX_W-1:0]   age;
  logic [DEPTH-1:0][OFF_W-1:0]  off;
  logic [DEPTH-1:0][RANK_W-1:0] rank;
  logic [DEPTH-1:0]             live, expd, pick;

  // modular age and encodability
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      age[i]  = cur_bx - ent[i].bx;
      off[i]  = OFF_W'(BX_W'(0) - age[i]);
      live[i] = vld[i] && (age[i] <= BX_W'(MAX_AGE));
      expd[i] = vld[i] && !live[i];
    end
  end

  // rank = number of live entries that go before this one
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rank[i] = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (live[j] && (j != i) &&
            ((age[j] > age[i]) || ((age[j] == age[i]) && (j < i))))
          rank[i] = rank[i] + RANK_W'(1);
      end
      pick[i] = live[i] && (rank[i] < RANK_W'(SLOTS));
    end
  end

  always_comb begin
    for (int k = 0; k < SLOTS; k++) begin
      prims[k] = EMPTY_PRIM;
      for (int i = 0; i < DEPTH; i++) begin
        if (pick[i] && (rank[i] == RANK_W'(k)))
          prims[k] = {ent[i].board, ent[i].chan, ent[i].subt, off[i]};
      end
    end
  end

  assign clr       = tick ? (pick | expd) : '0;
  assign n_expired = tick ? RANK_W'($countones(expd)) : '0;

  // R5
  pick_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pick) == (($countones(live) < SLOTS) ? $countones(live) : SLOTS));

  generate
    for (genvar k = 0; k < SLOTS - 1; k++) begin : g_fill
      // R7
      slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prims[k] == EMPTY_PRIM) |-> (prims[k+1] == EMPTY_PRIM));
    end
  endgenerate
endmodule

// File: rtl/tp_frame_builder.sv
module tp_frame_builder
  import tpf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int SLOTS   = 5,
  parameter int MAX_AGE = 15,
  parameter int DROP_W  = 8,
  localparam int FRAME_W = BX_W + SLOTS * PRIM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bx_tick,
  input  logic               hit_valid,
  output logic               hit_ready,
  input  logic [BOARD_W-1:0] hit_board,
  input  logic [CHAN_W-1:0]  hit_chan,
  input  logic [SUBT_W-1:0]  hit_subt,
  input  logic [BX_W-1:0]    hit_bx,
  output logic               frame_valid,
  output logic [FRAME_W-1:0] frame_data,
  output logic [DROP_W-1:0]  drop_count
);
  localparam int RANK_W = $clog2(DEPTH + 1);

  hit_t                         in_hit;
  logic [DEPTH-1:0]             vld, clr;
  hit_t [DEPTH-1:0]             ent;
  logic [SLOTS-1:0][PRIM_W-1:0] prims;
  logic [RANK_W-1:0]            n_expired;

  logic [BX_W-1:0]    bx_q, bx_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               fvld_q;
  logic [DROP_W-1:0]  drop_q, drop_d;
  logic [DROP_W:0]    drop_sum;

  assign in_hit = '{board: hit_board, chan: hit_chan, subt: hit_subt, bx: hit_bx};

  tpf_hit_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (hit_valid),
    .in_hit   (in_hit),
    .clr      (clr),
    .vld      (vld),
    .ent      (ent),
    .in_ready (hit_ready)
  );

  tpf_rank_select #(.DEPTH(DEPTH), .SLOTS(SLOTS), .MAX_AGE(MAX_AGE)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (bx_tick),
    .cur_bx    (bx_q),
    .vld       (vld),
    .ent       (ent),
    .prims     (prims),
    .clr       (clr),
    .n_expired (n_expired)
  );

  // next state
  always_comb begin
    bx_d = bx_tick ? bx_q + BX_W'(1) : bx_q;
    frame_d = '0;
    frame_d[FRAME_W-1 -: BX_W] = bx_q;
    for (int k = 0; k < SLOTS; k++)
      frame_d[FRAME_W-BX_W-1-k*PRIM_W -: PRIM_W] = prims[k];
    drop_sum = (DROP_W+1)'(drop_q) + (DROP_W+1)'(n_expired);
    drop_d   = drop_sum[DROP_W] ? '1 : drop_sum[DROP_W-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx_q   <= '0;
      fvld_q <= 1'b0;
      drop_q <= '0;
    end else begin
      bx_q   <= bx_d;
      fvld_q <= bx_tick;
      drop_q <= drop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frame_q <= '0;
    else if (bx_tick) frame_q <= frame_d;
  end

  assign frame_valid = fvld_q;
  assign frame_data  = frame_q;
  assign drop_count  = drop_q;

  // R1
  frame_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(bx_tick));

  // R1
  bx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bx_tick |=> (frame_data[FRAME_W-1 -: BX_W] + BX_W'(1) == bx_q));

  // R10
  drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_q >= $past(drop_q)));
endmodule

// File: tb/tb_tp_frame_builder.sv
module tb_tp_frame_builder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bx_tick, hit_valid, hit_ready;
  logic [4:0]  hit_board, hit_chan;
  logic [1:0]  hit_subt;
  logic [11:0] hit_bx;
  logic        frame_valid;
  logic [91:0] frame_data;
  logic [7:0]  drop_count;

  int checks = 0;
  int failures = 0;
  logic [11:0] bx_model = '0;
  int exp_drop = 0;

  always #10 clk = ~clk;

  tp_frame_builder dut (
    .clk(clk), .rst_n(rst_n), .bx_tick(bx_tick), .hit_valid(hit_valid),
    .hit_ready(hit_ready), .hit_board(hit_board), .hit_chan(hit_chan),
    .hit_subt(hit_subt), .hit_bx(hit_bx), .frame_valid(frame_valid),
    .frame_data(frame_data), .drop_count(drop_count)
  );

  // vector: {age[11:0], board[4:0], chan[4:0], subt[1:0]}
  localparam logic [23:0] VEC [8] = '{
    {12'd0,    5'd3,  5'd7,  2'd1},
    {12'd1,    5'd17, 5'd0,  2'd2},
    {12'd5,    5'd0,  5'd31, 2'd3},
    {12'd15,   5'd9,  5'd12, 2'd0},
    {12'd16,   5'd4,  5'd4,  2'd1},
    {12'd40,   5'd1,  5'd2,  2'd2},
    {12'd4095, 5'd2,  5'd2,  2'd0},
    {12'd8,    5'd16, 5'd21, 2'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] slot(input int k);
    return frame_data[79-16*k -: 16];
  endfunction

  function automatic int n_full();
    int n = 0;
    for (int k = 0; k < 5; k++) if (slot(k) != 16'hFFFF) n++;
    return n;
  endfunction

  function automatic logic [15:0] prim(input logic [4:0] b, input logic [4:0] c,
                                       input logic [1:0] s, input logic [11:0] age);
    logic [11:0] neg = 12'd0 - age;
    return {b, c, s, neg[3:0]};
  endfunction

  task automatic push(input logic [4:0] b, input logic [4:0] c,
                      input logic [1:0] s, input logic [11:0] bx);
    @(negedge clk);
    hit_valid = 1'b1; hit_board = b; hit_chan = c; hit_subt = s; hit_bx = bx;
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    bx_tick = 1'b1;
    @(negedge clk);
    bx_tick = 1'b0;
    chk("R1 frame_valid", 32'(frame_valid), 32'd1);
    chk("R3 crossing ID", 32'(frame_data[91:80]), 32'(bx_model));
    bx_model = bx_model + 12'd1;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bx_tick = 1'b0; hit_valid = 1'b0;
    hit_board = '0; hit_chan = '0; hit_subt = '0; hit_bx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 frame_valid", 32'(frame_valid), 32'd0);
    chk("R11 hit_ready", 32'(hit_ready), 32'd1);
    chk("R11 drop_count", 32'(drop_count), 32'd0);

    // table: single hit per frame at various ages (R2 R4 R7)
    for (int v = 0; v < 8; v++) begin
      logic [11:0] age = VEC[v][23:12];
      push(VEC[v][11:7], VEC[v][6:2], VEC[v][1:0], bx_model - age);
      tick();
      if (age <= 12'd15) begin
        chk("R2 slot0 primitive", 32'(slot(0)), 32'(prim(VEC[v][11:7], VEC[v][6:2], VEC[v][1:0], age)));
      end else begin
        exp_drop++;
        chk("R4 too-old hit not sent", 32'(slot(0)), 32'hFFFF);
      end
      chk("R7 slot1 empty", 32'(slot(1)), 32'hFFFF);
      chk("R4 drop_count", 32'(drop_count), 32'(exp_drop));
    end
    @(negedge clk);
    chk("R1 frame_valid one cycle", 32'(frame_valid), 32'd0);

    // R5: seven hits, five oldest first, two left over
    begin
      int ages [7] = '{3, 9, 1, 12, 0, 5, 7};
      int ord  [5] = '{3, 1, 6, 5, 0};
      for (int i = 0; i < 7; i++) push(5'(i), 5'd1, 2'd0, bx_model - 12'(ages[i]));
      tick();
      for (int k = 0; k < 5; k++)
        chk("R5 oldest-first slot", 32'(slot(k)), 32'(prim(5'(ord[k]), 5'd1, 2'd0, 12'(ages[ord[k]]))));
      tick();
      chk("R5 leftover slot0", 32'(slot(0)), 32'(prim(5'd2, 5'd1, 2'd0, 12'd2)));
      chk("R5 leftover slot1", 32'(slot(1)), 32'(prim(5'd4, 5'd1, 2'd0, 12'd1)));
      chk("R7 leftover frame count", 32'(n_full()), 32'd2);
    end

    // R6: six hits at age 15, one left behind expires
    for (int i = 0; i < 6; i++) push(5'd10, 5'(i), 2'd1, bx_model - 12'd15);
    tick();
    chk("R6 full frame", 32'(n_full()), 32'd5);
    chk("R2 age15 offset", 32'(slot(4) & 16'h000F), 32'h1);
    tick();
    exp_drop++;
    chk("R6 aged-out not sent", 32'(n_full()), 32'd0);
    chk("R6 drop_count", 32'(drop_count), 32'(exp_drop));

    // R8: queue full, 17th hit refused
    for (int i = 0; i < 16; i++) push(5'd5, 5'(i), 2'd0, bx_model);
    chk("R8 ready low when full", 32'(hit_ready), 32'd0);
    push(5'd6, 5'd6, 2'd0, bx_model);
    tick(); chk("R8 drain 1", 32'(n_full()), 32'd5);
    tick(); chk("R8 drain 2", 32'(n_full()), 32'd5);
    tick(); chk("R8 drain 3", 32'(n_full()), 32'd5);
    tick(); chk("R8 drain 4", 32'(n_full()), 32'd1);
    chk("R8 ready after drain", 32'(hit_ready), 32'd1);

    // R9: hit accepted in tick cycle belongs to later frame
    @(negedge clk);
    hit_valid = 1'b1; bx_tick = 1'b1;
    hit_board = 5'd12; hit_chan = 5'd3; hit_subt = 2'd2; hit_bx = bx_model;
    @(negedge clk);
    hit_valid = 1'b0; bx_tick = 1'b0;
    chk("R9 same-cycle hit absent", 32'(n_full()), 32'd0);
    bx_model = bx_model + 12'd1;
    tick();
    chk("R9 hit in next frame", 32'(slot(0)), 32'(prim(5'd12, 5'd3, 2'd2, 12'd1)));

    // R1 wrap of the crossing ID
    while (bx_model != 12'hFFF) tick();
    push(5'd7, 5'd8, 2'd1, 12'hFFE);
    tick();
    chk("R2 offset before wrap", 32'(slot(0)), 32'(prim(5'd7, 5'd8, 2'd1, 12'd1)));
    push(5'd7, 5'd9, 2'd1, 12'hFFF);
    tick();
    chk("R1 ID after wrap", 32'(frame_data[91:80]), 32'd0);
    chk("R2 offset across wrap", 32'(slot(0)), 32'(prim(5'd7, 5'd9, 2'd1, 12'd1)));

    // R10 saturation
    for (int r = 0; r < 17; r++) begin
      for (int i = 0; i < 16; i++) push(5'd1, 5'(i), 2'd0, bx_model - 12'd100);
      tick();
      exp_drop = (exp_drop + 16 > 255) ? 255 : exp_drop + 16;
    end
    chk("R10 drop_count saturated", 32'(drop_count), 32'd255);
    chk("R10 model at limit", 32'(exp_drop), 32'd255);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule